// File: doc/BRIEF.md
# Acknowledged Packet Transaction Sequencer

This block is the control engine that carries out a complete acknowledged packet exchange for a packet radio with no host help. The host loads a payload and a length and then pulses a transmit start. After that the sequencer turns on the oscillator and waits until it is ready. It then holds the synthesizer for a settle window chosen by channel class, lets the framer send the data packet, and turns the radio around to listen for an acknowledgement. The exchange ends when a valid ACK arrives or when a programmable cycle count runs out. The block then drops to the configured end state, which is sleep (everything off) or idle (oscillator kept running).

In receive transaction mode the sequencer listens on the channel. Each valid data packet is committed to the receive buffer, and an ACK frame is sent back at once. The sequencer then returns to listening for the next packet. ACK frames, whether received or sent, never touch the data buffers. A forced-end command stops any activity within one cycle. A five-bit status register with clear-on-read semantics drives a single interrupt line.

Top module: `xact_seq`

## Requirements
- R1: After reset, all radio enables (oscEn, synthEn, txEn, rxEn, sendAck) are low, irqStatus is 0 and irq is low.
- R2: A txGo pulse in sleep raises oscEn on the next cycle and waits for oscReady. The block then holds synthEn alone for exactly the settle window of chanClass: 0 gives 270 us, 1 gives 180 us, 2 and 3 give 100 us, each times CYC_PER_US cycles. After that it raises txEn until txDone.
- R3: After txDone the block raises rxEn to wait for an ACK. A valid ACK (rxDone with crcOk and rxIsAck) sets status bit 0 and moves to the end state.
- R4: The ACK wait lasts exactly ackTimeout cycles, and a value of 0 counts as 1. If no valid ACK arrives, status bit 1 is set and the block moves to the end state.
- R5: An endState of 3'b000 selects sleep, where every enable is low. Any other code selects idle, where only oscEn is high. A start command given in idle skips the oscillator wait and goes straight to the settle window.
- R6: rxGo starts receive mode. A valid packet that is not an ACK gives a one-cycle rxBufCommit pulse and sets status bit 2. The block then asserts txEn with sendAck until txDone, and then returns to listening (rxEn).
- R7: While listening, a packet with a failed CRC sets status bit 3, sends no ACK and keeps the block listening.
- R8: An ACK packet, received while listening or during the ACK wait, never produces rxBufCommit. An outgoing ACK is always flagged by sendAck, so the transmit buffer is not read for it.
- R9: A forceEnd pulse places the block in its end state on the next cycle from any state, and it overrides a start command given in the same cycle.
- R10: When oscIrqEn is high, the acceptance of oscReady at the end of the oscillator wait sets status bit 4.
- R11: An irqRd pulse clears every status flag, but a flag set in the same cycle is kept. irq is high whenever any status flag is set.
- R12: A start command given while a transaction is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| txGo | input | 1 | Start transmit transaction (pulse) |
| rxGo | input | 1 | Start receive transaction mode (pulse) |
| forceEnd | input | 1 | Force the end state (pulse) |
| endState | input | 3 | End state code, 000 = sleep, other values = idle |
| chanClass | input | 2 | Synthesizer settle class |
| ackTimeout | input | TO_W | ACK wait length in cycles |
| oscIrqEn | input | 1 | Enable the oscillator-stable flag |
| irqRd | input | 1 | Status read strobe that clears the flags |
| oscReady | input | 1 | Oscillator stable, from the RF model |
| txDone | input | 1 | Framer finished sending a frame |
| rxDone | input | 1 | Framer finished receiving a frame |
| crcOk | input | 1 | CRC of the received frame is good |
| rxIsAck | input | 1 | Received frame is an ACK |
| oscEn | output | 1 | Oscillator enable |
| synthEn | output | 1 | Synthesizer enable |
| txEn | output | 1 | Transmitter enable |
| rxEn | output | 1 | Receiver enable |
| sendAck | output | 1 | Framer sends an ACK frame instead of the buffer |
| rxBufCommit | output | 1 | Commit received payload to the buffer |
| irqStatus | output | 5 | Flags: bit 0 ACK received, 1 ACK timeout, 2 RX packet, 3 RX CRC error, 4 oscillator stable |
| irq | output | 1 | Interrupt, OR of the flags |

## Verification
The assertions check on every cycle the rules that relate neighbouring cycles. They check that a forced end lands in an end state on the next cycle, that sleep drops the oscillator, that a CRC failure never starts a transmission, and that an ACK window which has run out is always left. They also check that every outgoing ACK coincides with a buffer commit and that a read clears the flags. Only the bench scenarios can show the exact settle and timeout lengths, and that the order of radio phases is right for each channel class. The same holds for the idle shortcut, for packets being ignored during the ACK wait, and for the status contents after whole transactions.

// File: rtl/xact_pkg.sv
package xact_pkg;
  typedef enum logic [2:0] {
    ST_SLEEP, ST_IDLE, ST_OSC, ST_SYNTH, ST_TXDATA, ST_ACKWAIT, ST_LISTEN, ST_RXACK
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClr;
    logic selSettle;
    logic setTxOk;
    logic setTxTo;
    logic setRxPkt;
    logic setRxErr;
    logic setOsc;
  } seqStrobe_t;

  localparam int NUM_FLAGS  = 5;
  localparam int F_TX_OK    = 0;
  localparam int F_TX_TO    = 1;
  localparam int F_RX_PKT   = 2;
  localparam int F_RX_ERR   = 3;
  localparam int F_OSC      = 4;
endpackage

// File: rtl/xact_dp.sv
module xact_dp
  import xact_pkg::*;
#(
  parameter int SLOW_CYC = 270,
  parameter int MED_CYC  = 180,
  parameter int FAST_CYC = 100,
  parameter int TO_W     = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  seqStrobe_t           strb,
  input  logic [1:0]           chanClass,
  input  logic [TO_W-1:0]      ackTimeout,
  input  logic                 irqRd,
  output logic                 cntHit,
  output logic [NUM_FLAGS-1:0] irqStatus
);
  localparam int SET_MAX = (SLOW_CYC > MED_CYC) ?
                           ((SLOW_CYC > FAST_CYC) ? SLOW_CYC : FAST_CYC) :
                           ((MED_CYC > FAST_CYC) ? MED_CYC : FAST_CYC);
  localparam int SET_W = $clog2(SET_MAX + 1);
  localparam int CNT_W = (SET_W > TO_W) ? SET_W : TO_W;
  localparam logic [CNT_W-1:0] ONE = 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  logic [NUM_FLAGS-1:0] flagSet;

  always_comb begin
    if (strb.selSettle) begin
      case (chanClass)
        2'd0:    lim = CNT_W'(SLOW_CYC);
        2'd1:    lim = CNT_W'(MED_CYC);
        default: lim = CNT_W'(FAST_CYC);
      endcase
    end else if (ackTimeout == '0) begin
      lim = ONE;
    end else begin
      lim = CNT_W'(ackTimeout);
    end
  end

  assign cntHit = (cnt == (lim - ONE));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cnt <= '0;
    else if (strb.cntClr) cnt <= '0;
    else if (!cntHit)     cnt <= cnt + ONE;
  end

  always_comb begin
    flagSet           = '0;
    flagSet[F_TX_OK]  = strb.setTxOk;
    flagSet[F_TX_TO]  = strb.setTxTo;
    flagSet[F_RX_PKT] = strb.setRxPkt;
    flagSet[F_RX_ERR] = strb.setRxErr;
    flagSet[F_OSC]    = strb.setOsc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqStatus <= '0;
    else       irqStatus <= (irqRd ? '0 : irqStatus) | flagSet;
  end

  // R11: a read with nothing new leaves the flags empty
  a_r11_clear_on_read: assert property (@(posedge clk) disable iff (!rstN)
    (irqRd && (flagSet == '0)) |=> (irqStatus == '0));
  // R11: a flag set while reading survives
  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    strb.setRxErr |=> irqStatus[F_RX_ERR]);
endmodule

// File: rtl/xact_ctrl.sv
module xact_ctrl
  import xact_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       txGo,
  input  logic       rxGo,
  input  logic       forceEnd,
  input  logic [2:0] endState,
  input  logic       oscReady,
  input  logic       oscIrqEn,
  input  logic       txDone,
  input  logic       rxDone,
  input  logic       crcOk,
  input  logic       rxIsAck,
  input  logic       cntHit,
  output seqStrobe_t strb,
  output logic       oscEn,
  output logic       synthEn,
  output logic       txEn,
  output logic       rxEn,
  output logic       sendAck,
  output logic       rxBufCommit
);
  seqState_t st, nxt;
  seqState_t endTgt;
  logic txMode, txModeNxt;
  logic commitNxt;

  assign endTgt = (endState == 3'b000) ? ST_SLEEP : ST_IDLE;

  always_comb begin
    nxt       = st;
    txModeNxt = txMode;
    commitNxt = 1'b0;
    strb      = '0;
    case (st)
      ST_SLEEP: if (txGo || rxGo) begin nxt = ST_OSC; txModeNxt = txGo; end
      ST_IDLE:  if (txGo || rxGo) begin nxt = ST_SYNTH; txModeNxt = txGo; end
      ST_OSC:   if (oscReady) begin nxt = ST_SYNTH; strb.setOsc = oscIrqEn; end
      ST_SYNTH: begin
        strb.selSettle = 1'b1;
        if (cntHit) nxt = txMode ? ST_TXDATA : ST_LISTEN;
      end
      ST_TXDATA: if (txDone) nxt = ST_ACKWAIT;
      ST_ACKWAIT: begin
        if (rxDone && crcOk && rxIsAck) begin
          strb.setTxOk = 1'b1;
          nxt = endTgt;
        end else if (cntHit) begin
          strb.setTxTo = 1'b1;
          nxt = endTgt;
        end
      end
      ST_LISTEN: begin
        if (rxDone && !crcOk) begin
          strb.setRxErr = 1'b1;
        end else if (rxDone && !rxIsAck) begin
          strb.setRxPkt = 1'b1;
          commitNxt = 1'b1;
          nxt = ST_RXACK;
        end
      end
      ST_RXACK: if (txDone) nxt = ST_LISTEN;
      default: nxt = ST_SLEEP;
    endcase
    if (forceEnd) nxt = endTgt;
    strb.cntClr = (nxt != st) && ((nxt == ST_SYNTH) || (nxt == ST_ACKWAIT));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st          <= ST_SLEEP;
      txMode      <= 1'b0;
      rxBufCommit <= 1'b0;
    end else begin
      st          <= nxt;
      txMode      <= txModeNxt;
      rxBufCommit <= commitNxt && !forceEnd;
    end
  end

  assign oscEn   = (st != ST_SLEEP);
  assign synthEn = (st == ST_SYNTH) || (st == ST_TXDATA) || (st == ST_ACKWAIT) ||
                   (st == ST_LISTEN) || (st == ST_RXACK);
  assign txEn    = (st == ST_TXDATA) || (st == ST_RXACK);
  assign rxEn    = (st == ST_ACKWAIT) || (st == ST_LISTEN);
  assign sendAck = (st == ST_RXACK);

  // R9: forced end lands in an end state next cycle
  a_r9_force_end: assert property (@(posedge clk) disable iff (!rstN)
    forceEnd |=> ((st == ST_SLEEP) || (st == ST_IDLE)));
  // R5: sleep end state turns the oscillator off
  a_r5_sleep_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (forceEnd && (endState == 3'b000)) |=> !oscEn);
  // R7: a bad CRC never starts a transmission
  a_r7_no_ack_bad_crc: assert property (@(posedge clk) disable iff (!rstN)
    ((st == ST_LISTEN) && rxDone && !crcOk) |=> !txEn);
  // R4: an expired ACK window is always left
  a_r4_timeout_exit: assert property (@(posedge clk) disable iff (!rstN)
    ((st == ST_ACKWAIT) && cntHit) |=> (st != ST_ACKWAIT));
  // R8: an outgoing ACK always follows a buffer commit
  a_r8_ack_after_commit: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sendAck) |-> rxBufCommit);
  // R2: data transmission starts only after the settle window
  a_r2_tx_after_settle: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(txEn) && !sendAck) |-> ($past(st) == ST_SYNTH));
endmodule

// File: rtl/xact_seq.sv
module xact_seq
  import xact_pkg::*;
#(
  parameter int CYC_PER_US = 125,
  parameter int SLOW_US    = 270,
  parameter int MED_US     = 180,
  parameter int FAST_US    = 100,
  parameter int TO_W       = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 txGo,
  input  logic                 rxGo,
  input  logic                 forceEnd,
  input  logic [2:0]           endState,
  input  logic [1:0]           chanClass,
  input  logic [TO_W-1:0]      ackTimeout,
  input  logic                 oscIrqEn,
  input  logic                 irqRd,
  input  logic                 oscReady,
  input  logic                 txDone,
  input  logic                 rxDone,
  input  logic                 crcOk,
  input  logic                 rxIsAck,
  output logic                 oscEn,
  output logic                 synthEn,
  output logic                 txEn,
  output logic                 rxEn,
  output logic                 sendAck,
  output logic                 rxBufCommit,
  output logic [NUM_FLAGS-1:0] irqStatus,
  output logic                 irq
);
  localparam int SLOW_CYC = SLOW_US * CYC_PER_US;
  localparam int MED_CYC  = MED_US * CYC_PER_US;
  localparam int FAST_CYC = FAST_US * CYC_PER_US;

  seqStrobe_t strb;
  logic cntHit;

  xact_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .txGo(txGo), .rxGo(rxGo), .forceEnd(forceEnd),
    .endState(endState), .oscReady(oscReady), .oscIrqEn(oscIrqEn),
    .txDone(txDone), .rxDone(rxDone), .crcOk(crcOk), .rxIsAck(rxIsAck),
    .cntHit(cntHit), .strb(strb), .oscEn(oscEn), .synthEn(synthEn),
    .txEn(txEn), .rxEn(rxEn), .sendAck(sendAck), .rxBufCommit(rxBufCommit)
  );

  xact_dp #(
    .SLOW_CYC(SLOW_CYC), .MED_CYC(MED_CYC), .FAST_CYC(FAST_CYC), .TO_W(TO_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .chanClass(chanClass),
    .ackTimeout(ackTimeout), .irqRd(irqRd), .cntHit(cntHit), .irqStatus(irqStatus)
  );

  assign irq = |irqStatus;
endmodule

// File: tb/tb_xact_seq.sv
module tb_xact_seq;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txGo = 0, rxGo = 0, forceEnd = 0, oscIrqEn = 0, irqRd = 0;
  logic oscReady = 0, txDone = 0, rxDone = 0, crcOk = 0, rxIsAck = 0;
  logic [2:0] endState = 3'b000;
  logic [1:0] chanClass = 2'd0;
  logic [15:0] ackTimeout = 16'd20;
  logic oscEn, synthEn, txEn, rxEn, sendAck, rxBufCommit, irq;
  logic [4:0] irqStatus;

  always #4 clk = ~clk;

  xact_seq #(.CYC_PER_US(1)) dut (
    .clk(clk), .rstN(rstN), .txGo(txGo), .rxGo(rxGo), .forceEnd(forceEnd),
    .endState(endState), .chanClass(chanClass), .ackTimeout(ackTimeout),
    .oscIrqEn(oscIrqEn), .irqRd(irqRd), .oscReady(oscReady), .txDone(txDone),
    .rxDone(rxDone), .crcOk(crcOk), .rxIsAck(rxIsAck), .oscEn(oscEn),
    .synthEn(synthEn), .txEn(txEn), .rxEn(rxEn), .sendAck(sendAck),
    .rxBufCommit(rxBufCommit), .irqStatus(irqStatus), .irq(irq)
  );

  int nChk = 0, nBad = 0, commits = 0;
  bit monOn = 0;

  typedef struct { logic [4:0] v; int len; } item_t;
  item_t expQ[$];
  logic [4:0] prevV = 5'b0;
  int runLen = 0;

  task automatic chk(string req, int act, int exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(logic [4:0] v, int len);
    item_t it;
    it.v = v; it.len = len;
    expQ.push_back(it);
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: phase sequence {oscEn,synthEn,txEn,rxEn,sendAck} and phase lengths
  always @(negedge clk) begin
    logic [4:0] cur;
    item_t it;
    if (monOn) begin
      cur = {oscEn, synthEn, txEn, rxEn, sendAck};
      if (rxBufCommit) commits++;
      if (cur !== prevV) begin
        if (expQ.size() == 0) begin
          chk("R2 phase order (unexpected change)", int'(cur), int'(prevV));
        end else begin
          it = expQ.pop_front();
          chk("R2 phase order", int'(cur), int'(it.v));
          if (it.len != 0) chk("R2/R4 phase length", runLen, it.len);
        end
        prevV = cur;
        runLen = 1;
      end else begin
        runLen++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    cyc(3);
    rstN = 1'b1;
    cyc(1);
    // R1 reset state
    chk("R1 enables", int'({oscEn, synthEn, txEn, rxEn, sendAck}), 0);
    chk("R1 status", int'(irqStatus), 0);
    chk("R1 irq", int'(irq), 0);
    monOn = 1;

    // R2/R3/R10: TX from sleep, fast class, ACK received, end in idle
    endState = 3'b001; chanClass = 2'd2; ackTimeout = 16'd20; oscIrqEn = 1;
    push(5'b10000, 0); push(5'b11000, 0); push(5'b11100, 100);
    push(5'b11010, 0); push(5'b10000, 0);
    txGo = 1; cyc(1); txGo = 0;
    cyc(4); oscReady = 1;
    while (!txEn) cyc(1);
    cyc(3); txDone = 1; cyc(1); txDone = 0;
    while (!rxEn) cyc(1);
    cyc(5); rxDone = 1; crcOk = 1; rxIsAck = 1; cyc(1); rxDone = 0;
    cyc(2);
    chk("R3 ack flag with R10 osc flag", int'(irqStatus), 5'b10001);
    chk("R11 irq high", int'(irq), 1);
    irqRd = 1; cyc(1); irqRd = 0;
    chk("R11 clear on read", int'(irqStatus), 0);
    chk("R11 irq low", int'(irq), 0);

    // R4/R5/R8/R12: from idle, slow class, no ACK, end in sleep
    endState = 3'b000; chanClass = 2'd0; ackTimeout = 16'd20;
    push(5'b11000, 0); push(5'b11100, 270); push(5'b11010, 0); push(5'b00000, 20);
    txGo = 1; cyc(1); txGo = 0;
    while (!txEn) cyc(1);
    cyc(2); txDone = 1; cyc(1); txDone = 0;
    while (!rxEn) cyc(1);
    cyc(3); rxDone = 1; crcOk = 1; rxIsAck = 0; txGo = 1; cyc(1);
    rxDone = 0; txGo = 0;
    while (oscEn) cyc(1);
    cyc(1);
    chk("R4 timeout flag, R5 idle skips osc", int'(irqStatus), 5'b00010);
    chk("R8 no commit in ACK wait", commits, 0);
    oscReady = 0;
    irqRd = 1; cyc(1); irqRd = 0;

    // R6/R7/R8: receive mode from sleep, medium class, no osc flag
    endState = 3'b001; chanClass = 2'd1; oscIrqEn = 0;
    push(5'b10000, 0); push(5'b11000, 0); push(5'b11010, 180);
    rxGo = 1; cyc(1); rxGo = 0;
    cyc(3); oscReady = 1;
    while (!rxEn) cyc(1);
    cyc(2);
    rxDone = 1; crcOk = 0; rxIsAck = 0; cyc(1); rxDone = 0;
    cyc(3);
    chk("R7 bad CRC sends no ACK", int'(txEn), 0);
    chk("R7 still listening", int'(rxEn), 1);
    rxDone = 1; crcOk = 1; rxIsAck = 1; cyc(1); rxDone = 0;
    cyc(3);
    chk("R8 ACK while listening not committed", commits, 0);
    push(5'b11101, 0); push(5'b11010, 0);
    rxDone = 1; crcOk = 1; rxIsAck = 0; cyc(1); rxDone = 0;
    cyc(2); txDone = 1; cyc(1); txDone = 0;
    cyc(2);
    chk("R6 one commit pulse", commits, 1);
    chk("R6 packet flag with R7 error flag", int'(irqStatus), 5'b01100);
    chk("R6 back to listen", int'(rxEn), 1);
    irqRd = 1; rxDone = 1; crcOk = 0; cyc(1); irqRd = 0; rxDone = 0;
    cyc(1);
    chk("R11 set during read kept", int'(irqStatus), 5'b01000);

    // R9: forced end to idle, then to sleep, then priority over start
    push(5'b10000, 0);
    forceEnd = 1; cyc(1); forceEnd = 0;
    chk("R9 forced idle osc", int'(oscEn), 1);
    chk("R9 forced idle rx off", int'(rxEn), 0);
    endState = 3'b000;
    push(5'b00000, 0);
    forceEnd = 1; cyc(1); forceEnd = 0;
    chk("R9 forced sleep", int'(oscEn), 0);
    oscReady = 0;
    txGo = 1; forceEnd = 1; cyc(1); txGo = 0; forceEnd = 0;
    cyc(3);
    chk("R9 force beats start", int'(oscEn), 0);
    irqRd = 1; cyc(1); irqRd = 0;

    // R4/R2: timeout 0 counts as 1, class 3 uses fast window
    ackTimeout = 16'd0; chanClass = 2'd3;
    push(5'b10000, 0); push(5'b11000, 0); push(5'b11100, 100);
    push(5'b11010, 0); push(5'b00000, 1);
    txGo = 1; cyc(1); txGo = 0;
    cyc(2); oscReady = 1;
    while (!txEn) cyc(1);
    txDone = 1; cyc(1); txDone = 0;
    while (oscEn) cyc(1);
    cyc(1);
    chk("R4 zero timeout flag", int'(irqStatus), 5'b00010);
    cyc(3);
    chk("R2 all expected phases seen", expQ.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule